// File: doc/BRIEF.md
# Non-Blocking Send Admission with Feedback

This block sits in front of a link's transmit FIFO and decides, per message, whether the whole message goes in. A sender pushes a header beat followed by the payload beats. It never checks FIFO occupancy first, and it is never held off, because the block has no ready signal. On the header beat the block compares the payload size with the FIFO space it has not yet promised to anyone. It then either forwards every payload beat into the FIFO or swallows every payload beat. No partial message ever reaches the FIFO.

For every header the block issues one notification write to the address carried in that header. The write holds the header's sequence tag and an accepted/rejected flag, and the sender polls that location later. Retrying a rejected message is up to the sender. Free space is tracked as a credit count in beats. An admitted message reserves its full size at admission, and the link side returns one beat of credit each time it pops the FIFO.

The controller has three states:
- `ST_HDR` waits for a header.
- `ST_PASS` forwards an admitted payload.
- `ST_DROP` discards a rejected payload.

The transitions are:
- HDR→HDR on a header that carries no payload.
- HDR→PASS on an admitted header.
- HDR→DROP on a rejected header with payload.
- PASS→HDR and DROP→HDR on the last payload beat.

Top module: `send_admit`

## Requirements
- R1: Every beat with `in_valid` high is consumed in the cycle it is presented; there is no back-pressure. `in_valid` may drop between beats of a message, and each header produces exactly one notification.
- R2: The first valid beat in `ST_HDR` is a header. Its length in bytes is in bits [15:0], its notification address in bits [47:16] and its tag in bits [55:48]. The cycle after a header, `note_valid` is high for exactly one cycle with `note_addr` equal to the address, `note_data[7:0]` equal to the tag, and notifications in header arrival order.
- R3: The payload size is length>>4 beats of 16 bytes, with the low four length bits ignored. A message is accepted, with `note_data[8]`=1, exactly when its beat count is at least 1 and no greater than the free credit at the header cycle.
- R4: Each payload beat of an accepted message appears on `fifo_wr_data` with `fifo_wr_en` high one cycle after it is presented, unchanged and in order.
- R5: The payload beats of a rejected message are consumed with `fifo_wr_en` staying low. The valid beat after the last discarded beat is treated as a header.
- R6: A length below 16 bytes (zero beats) is rejected and has no payload, so the next valid beat is a header. A length above the FIFO capacity of 1024 beats is always rejected.
- R7: Admission takes the message's beat count from the free credit at the header's clock edge. Each `fifo_pop` cycle returns one beat, so a later header sees the reduced space until pops restore it.
- R8: After reset `note_valid` and `fifo_wr_en` are low, the free credit equals the full FIFO (1024 beats), and the next valid beat is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sender beat valid |
| in_data | input | 128 | Header or payload beat |
| fifo_pop | input | 1 | Link side removed one beat from the FIFO |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 128 | FIFO write data |
| note_valid | output | 1 | Notification write strobe |
| note_addr | output | 32 | Notification target address |
| note_data | output | 9 | Tag in [7:0], accepted flag in [8] |

## Verification
Every result of this block is due exactly one clock after the beat that causes it. The notification follows its header by one cycle, and each forwarded FIFO write follows its payload beat by one cycle. Credit taken at admission and credit returned by a pop both count from the next header onward. The bench drives each beat at a falling edge and compares the outputs at the following falling edge against values its model predicted for that beat. In the same step the model updates its credit, so every comparison lands in the one cycle where that result is present.

// File: rtl/send_admit_pkg.sv
package send_admit_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } sa_state_e;

endpackage

// File: rtl/send_admit_credit.sv
module send_admit_credit #(
    parameter int FIFO_BEATS = 1024,
    parameter int CNT_W      = 11,
    parameter int BEAT_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BEAT_W-1:0] take_beats,
    input  logic              give,
    output logic [CNT_W-1:0]  free_beats
);

    logic [31:0] sub_amt;
    logic [31:0] add_amt;

    always_comb begin
        sub_amt = take ? 32'(take_beats) : 32'd0;
        add_amt = give ? 32'd1 : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_beats <= CNT_W'(FIFO_BEATS);
        end else begin
            free_beats <= CNT_W'(32'(free_beats) - sub_amt + add_amt);
        end
    end

endmodule

// File: rtl/send_admit_fsm.sv
module send_admit_fsm
    import send_admit_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 8,
    parameter int BEAT_W = 12,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BEAT_W-1:0] hdr_beats,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [TAG_W-1:0]  hdr_tag,
    input  logic [CNT_W-1:0]  free_beats,
    output sa_state_e         state,
    output logic              grant,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              note_valid,
    output logic [ADDR_W-1:0] note_addr,
    output logic [TAG_W:0]    note_data
);

    sa_state_e         state_d;
    logic [BEAT_W-1:0] remain_q;
    logic              hdr_fire;
    logic              fits;
    logic              last_beat;

    always_comb begin
        hdr_fire  = (state == ST_HDR) && in_valid;
        fits      = (hdr_beats != '0) && (32'(hdr_beats) <= 32'(free_beats));
        grant     = hdr_fire && fits;
        last_beat = in_valid && (remain_q == BEAT_W'(1));
        state_d   = state;
        unique case (state)
            ST_HDR: begin
                if (hdr_fire && (hdr_beats != '0)) begin
                    state_d = fits ? ST_PASS : ST_DROP;
                end
            end
            ST_PASS, ST_DROP: begin
                if (last_beat) begin
                    state_d = ST_HDR;
                end
            end
            default: state_d = ST_HDR;
        endcase
    end

    // state register and payload beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HDR;
            remain_q <= '0;
        end else begin
            state <= state_d;
            if (hdr_fire) begin
                remain_q <= hdr_beats;
            end else if (in_valid && (state != ST_HDR)) begin
                remain_q <= remain_q - BEAT_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
            note_valid   <= 1'b0;
            note_addr    <= '0;
            note_data    <= '0;
        end else begin
            fifo_wr_en <= (state == ST_PASS) && in_valid;
            note_valid <= hdr_fire;
            if ((state == ST_PASS) && in_valid) begin
                fifo_wr_data <= in_data;
            end
            if (hdr_fire) begin
                note_addr <= hdr_addr;
                note_data <= {fits, hdr_tag};
            end
        end
    end

endmodule

// File: rtl/send_admit.sv
module send_admit
    import send_admit_pkg::*;
#(
    parameter int  BEAT_BYTES = 16,
    parameter int  FIFO_BYTES = 16384,
    parameter int  LEN_W      = 16,
    parameter int  ADDR_W     = 32,
    parameter int  TAG_W      = 8,
    localparam int DATA_W     = BEAT_BYTES * 8,
    localparam int NOTE_W     = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fifo_pop,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              note_valid,
    output logic [ADDR_W-1:0] note_addr,
    output logic [NOTE_W-1:0] note_data
);

    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
    localparam int BEAT_W     = LEN_W - BEAT_SHIFT;
    localparam int FIFO_BEATS = FIFO_BYTES / BEAT_BYTES;
    localparam int CNT_W      = $clog2(FIFO_BEATS + 1);
    localparam int ADDR_LSB   = LEN_W;
    localparam int TAG_LSB    = LEN_W + ADDR_W;

    logic [LEN_W-1:0]  hdr_len;
    logic [BEAT_W-1:0] hdr_beats;
    logic [ADDR_W-1:0] hdr_addr;
    logic [TAG_W-1:0]  hdr_tag;
    logic [CNT_W-1:0]  free_beats;
    logic              grant;
    sa_state_e         st;

    always_comb begin
        hdr_len   = in_data[LEN_W-1:0];
        hdr_beats = hdr_len[LEN_W-1:BEAT_SHIFT];
        hdr_addr  = in_data[ADDR_LSB +: ADDR_W];
        hdr_tag   = in_data[TAG_LSB +: TAG_W];
    end

    send_admit_credit #(
        .FIFO_BEATS(FIFO_BEATS),
        .CNT_W     (CNT_W),
        .BEAT_W    (BEAT_W)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (grant),
        .take_beats(hdr_beats),
        .give      (fifo_pop),
        .free_beats(free_beats)
    );

    send_admit_fsm #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .TAG_W (TAG_W),
        .BEAT_W(BEAT_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .hdr_beats   (hdr_beats),
        .hdr_addr    (hdr_addr),
        .hdr_tag     (hdr_tag),
        .free_beats  (free_beats),
        .state       (st),
        .grant       (grant),
        .fifo_wr_en  (fifo_wr_en),
        .fifo_wr_data(fifo_wr_data),
        .note_valid  (note_valid),
        .note_addr   (note_addr),
        .note_data   (note_data)
    );

endmodule

// File: rtl/send_admit_chk.sv
module send_admit_chk
    import send_admit_pkg::*;
#(
    parameter int FIFO_BEATS = 1024,
    parameter int CNT_W      = 11,
    parameter int BEAT_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input sa_state_e         st,
    input logic              grant,
    input logic [BEAT_W-1:0] hdr_beats,
    input logic [CNT_W-1:0]  free_beats,
    input logic              fifo_wr_en,
    input logic              note_valid,
    input logic              note_acc
);

    // R2: a header is answered in the next cycle
    a_r2_note_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR && in_valid) |=> note_valid);

    // R2: no notification without a header one cycle earlier
    a_r2_note_needs_header: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> $past(st == ST_HDR && in_valid));

    // R3: a credit take never exceeds the free space and never is empty
    a_r3_grant_fits: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (hdr_beats != '0) && (32'(hdr_beats) <= 32'(free_beats)));

    // R3: reported outcome agrees with the credit take
    a_r3_flag_matches_take: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> (note_acc == $past(grant)));

    // R5: FIFO writes only follow beats seen while forwarding
    a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_PASS && in_valid) |=> !fifo_wr_en);

    // R7: credit never exceeds the FIFO capacity
    a_r7_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_beats) <= FIFO_BEATS);

endmodule

bind send_admit send_admit_chk #(
    .FIFO_BEATS(FIFO_BEATS),
    .CNT_W     (CNT_W),
    .BEAT_W    (BEAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .st        (st),
    .grant     (grant),
    .hdr_beats (hdr_beats),
    .free_beats(free_beats),
    .fifo_wr_en(fifo_wr_en),
    .note_valid(note_valid),
    .note_acc  (note_data[TAG_W])
);

// File: tb/send_admit_test.sv
module send_admit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         fifo_pop = 1'b0;
    logic         fifo_wr_en;
    logic [127:0] fifo_wr_data;
    logic         note_valid;
    logic [31:0]  note_addr;
    logic [8:0]   note_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state: 0 header, 1 forward, 2 discard
    int    mstate = 0;
    int    mremain = 0;
    int    mfree = 1024;
    int    mwritten = 0;
    int    mpopped = 0;
    int    n_hdr = 0;
    int    n_note = 0;
    string acc_req = "R3";

    always #5 clk = ~clk;

    send_admit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .fifo_pop    (fifo_pop),
        .fifo_wr_en  (fifo_wr_en),
        .fifo_wr_data(fifo_wr_data),
        .note_valid  (note_valid),
        .note_addr   (note_addr),
        .note_data   (note_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_hdr(input int len, input logic [31:0] addr,
                                            input logic [7:0] tag);
        return {72'd0, tag, addr, 16'(len)};
    endfunction

    task automatic step(input bit v, input logic [127:0] d, input bit pop);
        bit           e_wr = 0;
        logic [127:0] e_wd = '0;
        bit           e_nv = 0;
        logic [31:0]  e_na = '0;
        logic [8:0]   e_nd = '0;
        bit           pop_ok;
        string        wreq;
        int           beats;
        bit           acc;
        pop_ok   = pop && (mwritten > mpopped);
        in_valid = v;
        in_data  = d;
        fifo_pop = pop_ok;
        wreq     = (mstate == 1) ? "R4" : "R5";
        if (v) begin
            if (mstate == 0) begin
                beats = int'(d[15:4]);
                acc   = (beats != 0) && (beats <= mfree);
                e_nv  = 1;
                e_na  = d[47:16];
                e_nd  = {acc, d[55:48]};
                n_hdr++;
                if (acc) mfree -= beats;
                mremain = beats;
                mstate  = (beats == 0) ? 0 : (acc ? 1 : 2);
            end else begin
                if (mstate == 1) begin
                    e_wr = 1;
                    e_wd = d;
                    mwritten++;
                end
                mremain--;
                if (mremain == 0) mstate = 0;
            end
        end
        if (pop_ok) begin
            mpopped++;
            mfree++;
        end
        @(negedge clk);
        if (note_valid) n_note++;
        chk(note_valid == e_nv, "R2", "note_valid", 128'(note_valid), 128'(e_nv));
        if (e_nv && note_valid) begin
            chk(note_addr == e_na, "R2", "note_addr", 128'(note_addr), 128'(e_na));
            chk(note_data[7:0] == e_nd[7:0], "R2", "note tag", 128'(note_data[7:0]), 128'(e_nd[7:0]));
            chk(note_data[8] == e_nd[8], acc_req, "accept flag", 128'(note_data[8]), 128'(e_nd[8]));
        end
        chk(fifo_wr_en == e_wr, wreq, "fifo_wr_en", 128'(fifo_wr_en), 128'(e_wr));
        if (e_wr && fifo_wr_en) begin
            chk(fifo_wr_data == e_wd, "R4", "fifo_wr_data", fifo_wr_data, e_wd);
        end
    endtask

    function automatic logic [127:0] rnd_beat();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic send_msg(input int len, input logic [7:0] tag,
                            input int gap_pct, input int pop_pct);
        step(1'b1, mk_hdr(len, $urandom(), tag), ($urandom() % 100) < pop_pct);
        for (int i = 0; i < (len >> 4); i++) begin
            while (($urandom() % 100) < gap_pct) begin
                step(1'b0, '0, ($urandom() % 100) < pop_pct);
            end
            step(1'b1, rnd_beat(), ($urandom() % 100) < pop_pct);
        end
    endtask

    task automatic drain();
        while (mwritten > mpopped) step(1'b0, '0, 1'b1);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R8: quiet outputs under reset
        chk(note_valid == 1'b0, "R8", "note_valid in reset", 128'(note_valid), 128'd0);
        chk(fifo_wr_en == 1'b0, "R8", "fifo_wr_en in reset", 128'(fifo_wr_en), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8/R7: full credit after reset admits the largest message
        acc_req = "R8";
        send_msg(16384, 8'h11, 0, 0);
        // R7: reserved space leaves nothing for the next one
        acc_req = "R7";
        send_msg(256, 8'h12, 0, 0);
        for (int i = 0; i < 16; i++) step(1'b0, '0, 1'b1);
        send_msg(256, 8'h13, 0, 0);
        send_msg(16, 8'h14, 0, 0);
        drain();

        // R6: zero-beat headers back to back, then oversize
        acc_req = "R6";
        send_msg(0, 8'h21, 0, 0);
        send_msg(8, 8'h22, 0, 0);
        send_msg(16400, 8'h23, 10, 0);
        // R5: header right after a discarded payload is recognised
        acc_req = "R5";
        send_msg(32, 8'h24, 0, 0);
        drain();

        // R1/R3: random lengths, gaps and pops
        acc_req = "R3";
        for (int m = 0; m < 300; m++) begin
            int kind;
            int len;
            kind = int'($urandom() % 10);
            if (kind == 0)      len = int'($urandom() % 16);
            else if (kind == 1) len = 16 * (1 + int'($urandom() % 1100));
            else                len = 16 * (1 + int'($urandom() % 300)) + int'($urandom() % 16);
            if (len > 17600) len = 17600;
            send_msg(len, 8'(m), 30, 35);
        end
        drain();
        step(1'b0, '0, 1'b0);

        // R1: one notification per header, nothing left unconsumed
        chk(n_note == n_hdr, "R1", "notification count", 128'(n_note), 128'(n_hdr));

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule